// File: doc/BRIEF.md
# Dual-Group Conversion Sequencer for a Multiplexed ADC

This block drives a shared analog-to-digital converter that sits behind a 16-way input multiplexer. It runs two programmable conversion lists over that one converter. The primary list holds up to 16 slots. The priority list holds up to 4 slots. Each slot carries a 4-bit channel code. The same channel may fill several slots, and the slots may name channels in any order. Each list is started by its own single-cycle strobe. For every slot the block puts the channel code on `conv_chan` and pulses `conv_start`. It then waits for the converter to answer on `conv_done` and stores `conv_data` in a result register.

A power enable gates the whole block. Raising it lets a prescaler produce a converter clock enable, `adc_tick`, at one of four division ratios. The converter counts as ready only after a fixed number of those ticks has passed. Lowering the enable abandons all work at once and returns the converter to power-down.

A priority start that arrives during a primary run waits for the conversion in flight to finish. The whole priority list then runs, and after it the primary list continues from its next slot. A sticky end flag for each list reports completion until software clears it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A primary start runs slots 0 through `reg_len` in order, so `reg_len` holds the count minus one and covers 1 to 16 conversions. Slot i takes its channel from bits [4i+3:4i] of `reg_chans`, and repeated channels are converted as often as they appear.
- R2: A priority start runs slots 0 through `inj_len` in order, covering 1 to 4 conversions. Slot i takes its channel from bits [4i+3:4i] of `inj_chans`.
- R3: A start strobe is taken only while `pwr_en` is high. A strobe given while `pwr_en` is low produces no conversion and sets no flag, even after power is later applied.
- R4: A priority start given while primary slot k is converting takes effect once slot k completes. The priority list then runs in full, and the primary list resumes at slot k+1.
- R5: Each completed primary conversion loads `conv_data` into `reg_data`. Completed priority slot i loads `conv_data` into bits [12i+11:12i] of `inj_data`.
- R6: `reg_end` and `inj_end` are set when the last slot of their list completes. Each stays set until its clear strobe (`reg_clr` or `inj_clr`) is given. A set and a clear in the same cycle leave the flag set.
- R7: While powered, `adc_tick` pulses once every 2*(`div_sel`+1) clock cycles: 00 gives 2 and 11 gives 8. A new `div_sel` is adopted only while no conversion list is active.
- R8: After `pwr_en` rises, `adc_ready` rises once STAB_TICKS ticks have passed. No conversion starts before `adc_ready` is high.
- R9: Lowering `pwr_en` drops `adc_ready` at the next clock and abandons both lists. No conversion issues afterwards, and the abandoned lists do not resume when power returns.
- R10: `conv_start` is a single-cycle pulse that coincides with `adc_tick`, occurs only while ready, and never repeats while a conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable for the converter |
| div_sel | input | 2 | Converter clock ratio select |
| reg_start | input | 1 | Primary list start strobe |
| inj_start | input | 1 | Priority list start strobe |
| reg_len | input | 4 | Primary list length minus one |
| inj_len | input | 2 | Priority list length minus one |
| reg_chans | input | 64 | Primary slot channel codes, 4 bits per slot |
| inj_chans | input | 16 | Priority slot channel codes, 4 bits per slot |
| reg_clr | input | 1 | Clear strobe for the primary end flag |
| inj_clr | input | 1 | Clear strobe for the priority end flag |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_data | input | 12 | Converter result |
| adc_tick | output | 1 | Prescaled converter clock enable |
| adc_ready | output | 1 | Converter is powered and settled |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 4 | Multiplexer channel select |
| reg_data | output | 12 | Last primary result |
| inj_data | output | 48 | Priority results, 12 bits per slot |
| reg_end | output | 1 | Sticky primary end flag |
| inj_end | output | 1 | Sticky priority end flag |

## Verification
The assertions take several things about the inputs for granted. Start and clear strobes last one cycle. The channel tables and lengths stay unchanged while their list is active. The converter raises `conv_done` only for one cycle and only after a start it was given. The stimulus keeps to this in three ways. Tables and lengths are written before each start and left alone until both end flags are seen. The converter model answers each start exactly once, after a latency of at least two cycles. A priority start is given only while a primary conversion is known to be in flight.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DEF_CH_W       = 4;
    localparam int DEF_REG_SLOTS  = 16;
    localparam int DEF_INJ_SLOTS  = 4;
    localparam int DEF_DATA_W     = 12;
    localparam int DEF_DIV_W      = 2;
    localparam int DEF_STAB_TICKS = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARM  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PW_OFF   = 2'd0,
        PW_WARM  = 2'd1,
        PW_READY = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic reg_on;
        logic inj_on;
    } grp_act_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // ratio 2*(sel+1), so the last count is 2*sel+1
    assign lim  = {sel_q, 1'b1};
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (!hold) begin
            sel_q <= sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt >= lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: ratio is at least two, so ticks never touch
    a_r7_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
    import adc_seq_pkg::*;
#(
    parameter int STAB_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_en,
    input  logic tick,
    output logic ready
);
    localparam int SW = $clog2(STAB_TICKS + 1);

    pwr_state_e    st;
    logic [SW-1:0] stab;

    assign ready = (st == PW_READY);

    always_ff @(posedge clk) begin
        if (rst || !pwr_en) begin
            st   <= PW_OFF;
            stab <= '0;
        end else begin
            unique case (st)
                PW_OFF: begin
                    st   <= PW_WARM;
                    stab <= '0;
                end
                PW_WARM: begin
                    if (tick) begin
                        if (stab == SW'(STAB_TICKS - 1)) begin
                            st <= PW_READY;
                        end else begin
                            stab <= stab + 1'b1;
                        end
                    end
                end
                PW_READY: st <= PW_READY;
                default:  st <= PW_OFF;
            endcase
        end
    end

    // R9: losing the enable drops readiness at the next edge
    a_r9_ready_drop: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !ready);

    // R8: readiness only appears on a converter tick
    a_r8_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(tick));

endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W      = 4,
    parameter int REG_SLOTS = 16,
    parameter int INJ_SLOTS = 4,
    parameter int DATA_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_en,
    input  logic                         ready,
    input  logic                         tick,
    input  logic                         reg_start,
    input  logic                         inj_start,
    input  logic [$clog2(REG_SLOTS)-1:0] reg_len,
    input  logic [$clog2(INJ_SLOTS)-1:0] inj_len,
    input  logic [REG_SLOTS*CH_W-1:0]    reg_chans,
    input  logic [INJ_SLOTS*CH_W-1:0]    inj_chans,
    input  logic                         reg_clr,
    input  logic                         inj_clr,
    input  logic                         conv_done,
    input  logic [DATA_W-1:0]            conv_data,
    output logic                         busy,
    output logic                         conv_start,
    output logic [CH_W-1:0]              conv_chan,
    output logic [DATA_W-1:0]            reg_data,
    output logic [INJ_SLOTS*DATA_W-1:0]  inj_data,
    output logic                         reg_end,
    output logic                         inj_end
);
    localparam int RIDX_W = $clog2(REG_SLOTS);
    localparam int IIDX_W = $clog2(INJ_SLOTS);

    seq_state_e        st;
    grp_act_t          act;
    logic [RIDX_W-1:0] reg_idx;
    logic [IIDX_W-1:0] inj_idx;
    logic              cur_inj;

    logic done_ok, wr_reg, wr_inj, reg_last, inj_last;

    assign done_ok  = pwr_en && (st == SQ_WAIT) && conv_done;
    assign wr_reg   = done_ok && !cur_inj;
    assign wr_inj   = done_ok && cur_inj;
    assign reg_last = (reg_idx == reg_len);
    assign inj_last = (inj_idx == inj_len);

    assign conv_start = (st == SQ_ARM) && tick;
    assign conv_chan  = cur_inj ? inj_chans[inj_idx*CH_W +: CH_W]
                                : reg_chans[reg_idx*CH_W +: CH_W];
    assign busy = act.reg_on || act.inj_on || (st != SQ_IDLE);

    // slot sequencing; priority is chosen only between conversions
    always_ff @(posedge clk) begin
        if (rst || !pwr_en) begin
            st      <= SQ_IDLE;
            act     <= '0;
            reg_idx <= '0;
            inj_idx <= '0;
            cur_inj <= 1'b0;
        end else begin
            if (reg_start && !act.reg_on) begin
                act.reg_on <= 1'b1;
                reg_idx    <= '0;
            end
            if (inj_start && !act.inj_on) begin
                act.inj_on <= 1'b1;
                inj_idx    <= '0;
            end
            unique case (st)
                SQ_IDLE: begin
                    if (ready && (act.inj_on || act.reg_on)) begin
                        cur_inj <= act.inj_on;
                        st      <= SQ_ARM;
                    end
                end
                SQ_ARM: begin
                    if (tick) st <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (conv_done) begin
                        st <= SQ_IDLE;
                        if (cur_inj) begin
                            if (inj_last) begin
                                act.inj_on <= 1'b0;
                                inj_idx    <= '0;
                            end else begin
                                inj_idx <= inj_idx + 1'b1;
                            end
                        end else begin
                            if (reg_last) begin
                                act.reg_on <= 1'b0;
                                reg_idx    <= '0;
                            end else begin
                                reg_idx <= reg_idx + 1'b1;
                            end
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_data <= '0;
        end else if (wr_reg) begin
            reg_data <= conv_data;
        end
    end

    for (genvar gi = 0; gi < INJ_SLOTS; gi++) begin : g_inj_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_inj && (inj_idx == IIDX_W'(gi))) begin
                q <= conv_data;
            end
        end
        assign inj_data[gi*DATA_W +: DATA_W] = q;
    end

    // sticky end flags, set dominates clear
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_end <= 1'b0;
            inj_end <= 1'b0;
        end else begin
            if (wr_reg && reg_last)  reg_end <= 1'b1;
            else if (reg_clr)        reg_end <= 1'b0;
            if (wr_inj && inj_last)  inj_end <= 1'b1;
            else if (inj_clr)        inj_end <= 1'b0;
        end
    end

    // R10: start is a lone pulse
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R10, R8: start only on a tick of a settled converter
    a_r10_tick_ready: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (tick && ready));

    // R6: primary flag only rises from a converter answer
    a_r6_reg_end_src: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_end) |-> $past(conv_done && pwr_en));

    // R6: priority flag only rises from a converter answer
    a_r6_inj_end_src: assert property (@(posedge clk) disable iff (rst)
        $rose(inj_end) |-> $past(conv_done && pwr_en));

    // R9: power loss leaves nothing active
    a_r9_abandon: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !busy);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W       = DEF_CH_W,
    parameter int REG_SLOTS  = DEF_REG_SLOTS,
    parameter int INJ_SLOTS  = DEF_INJ_SLOTS,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int DIV_W      = DEF_DIV_W,
    parameter int STAB_TICKS = DEF_STAB_TICKS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_en,
    input  logic [DIV_W-1:0]             div_sel,
    input  logic                         reg_start,
    input  logic                         inj_start,
    input  logic [$clog2(REG_SLOTS)-1:0] reg_len,
    input  logic [$clog2(INJ_SLOTS)-1:0] inj_len,
    input  logic [REG_SLOTS*CH_W-1:0]    reg_chans,
    input  logic [INJ_SLOTS*CH_W-1:0]    inj_chans,
    input  logic                         reg_clr,
    input  logic                         inj_clr,
    input  logic                         conv_done,
    input  logic [DATA_W-1:0]            conv_data,
    output logic                         adc_tick,
    output logic                         adc_ready,
    output logic                         conv_start,
    output logic [CH_W-1:0]              conv_chan,
    output logic [DATA_W-1:0]            reg_data,
    output logic [INJ_SLOTS*DATA_W-1:0]  inj_data,
    output logic                         reg_end,
    output logic                         inj_end
);
    logic seq_busy;

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (pwr_en),
        .hold (seq_busy),
        .sel  (div_sel),
        .tick (adc_tick)
    );

    adc_pwr_ctrl #(.STAB_TICKS(STAB_TICKS)) u_pwr (
        .clk    (clk),
        .rst    (rst),
        .pwr_en (pwr_en),
        .tick   (adc_tick),
        .ready  (adc_ready)
    );

    adc_group_seq #(
        .CH_W      (CH_W),
        .REG_SLOTS (REG_SLOTS),
        .INJ_SLOTS (INJ_SLOTS),
        .DATA_W    (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pwr_en     (pwr_en),
        .ready      (adc_ready),
        .tick       (adc_tick),
        .reg_start  (reg_start),
        .inj_start  (inj_start),
        .reg_len    (reg_len),
        .inj_len    (inj_len),
        .reg_chans  (reg_chans),
        .inj_chans  (inj_chans),
        .reg_clr    (reg_clr),
        .inj_clr    (inj_clr),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .busy       (seq_busy),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .reg_data   (reg_data),
        .inj_data   (inj_data),
        .reg_end    (reg_end),
        .inj_end    (inj_end)
    );

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int STAB       = 4;

    logic        clk = 1'b0;
    logic        rst, pwr_en;
    logic [1:0]  div_sel;
    logic        reg_start, inj_start, reg_clr, inj_clr;
    logic [3:0]  reg_len;
    logic [1:0]  inj_len;
    logic [63:0] reg_chans;
    logic [15:0] inj_chans;
    logic        conv_done;
    logic [11:0] conv_data;
    logic        adc_tick, adc_ready, conv_start;
    logic [3:0]  conv_chan;
    logic [11:0] reg_data;
    logic [47:0] inj_data;
    logic        reg_end, inj_end;

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;
    int lat = 3;
    int log_n = 0;
    int log_ch [0:63];
    int ex_ch  [0:63];
    bit ex_inj [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .div_sel(div_sel),
        .reg_start(reg_start), .inj_start(inj_start),
        .reg_len(reg_len), .inj_len(inj_len),
        .reg_chans(reg_chans), .inj_chans(inj_chans),
        .reg_clr(reg_clr), .inj_clr(inj_clr),
        .conv_done(conv_done), .conv_data(conv_data),
        .adc_tick(adc_tick), .adc_ready(adc_ready),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .reg_data(reg_data), .inj_data(inj_data),
        .reg_end(reg_end), .inj_end(inj_end)
    );

    function automatic logic [11:0] exp_data(input int k, input int ch);
        return {4'(ch), 8'(k)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // converter model: answers each start once after lat cycles
    initial begin
        int k;
        logic [3:0] ch;
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            if (conv_start === 1'b1) begin
                k  = log_n;
                ch = conv_chan;
                if (k < 64) log_ch[k] = int'(ch);
                log_n = k + 1;
                repeat (lat) @(negedge clk);
                conv_data = exp_data(k, int'(ch));
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic wait_log(input int n);
        int guard = 0;
        while (log_n < n && guard < 50000) begin
            @(negedge clk); #1;
            guard++;
        end
    endtask

    task automatic measure(output int p);
        int c = 0;
        do @(negedge clk); while (!adc_tick);
        do begin @(negedge clk); c++; end while (!adc_tick);
        p = c;
    endtask

    task automatic strobe_reg();
        @(negedge clk); reg_start = 1'b1;
        @(negedge clk); reg_start = 1'b0;
    endtask

    task automatic strobe_inj();
        @(negedge clk); inj_start = 1'b1;
        @(negedge clk); inj_start = 1'b0;
    endtask

    task automatic run_seq(input int rl, input int il, input int inj_at,
                           input bit use_reg, input bit use_inj, input string tag);
        int ne, lr, j, guard;
        ne = 0; lr = -1; j = 0; guard = 0;
        reg_len = 4'(rl - 1);
        inj_len = 2'(il - 1);
        @(negedge clk); #1;
        log_n = 0;
        if (use_reg) strobe_reg();
        else if (use_inj) strobe_inj();
        if (use_reg && use_inj) begin
            wait_log(inj_at + 1);
            inj_start = 1'b1;
            @(negedge clk);
            inj_start = 1'b0;
        end
        if (use_reg) begin
            for (int i = 0; i < rl; i++) begin
                ex_ch[ne] = int'(reg_chans[i*4 +: 4]); ex_inj[ne] = 1'b0; ne++;
                if (use_inj && i == inj_at) begin
                    for (int q = 0; q < il; q++) begin
                        ex_ch[ne] = int'(inj_chans[q*4 +: 4]); ex_inj[ne] = 1'b1; ne++;
                    end
                end
            end
        end else begin
            for (int q = 0; q < il; q++) begin
                ex_ch[ne] = int'(inj_chans[q*4 +: 4]); ex_inj[ne] = 1'b1; ne++;
            end
        end
        while (guard < 50000 && !((!use_reg || reg_end) && (!use_inj || inj_end))) begin
            @(negedge clk); guard++;
        end
        cyc(1);
        chk({tag, " conversion count"}, log_n, ne);
        for (int i = 0; i < ne; i++) begin
            chk({tag, " channel order"}, log_ch[i], ex_ch[i]);
            if (ex_inj[i]) begin
                chk("R5 priority slot result", int'(inj_data[j*12 +: 12]), int'(exp_data(i, ex_ch[i])));
                j++;
            end else begin
                lr = i;
            end
        end
        if (use_reg) begin
            chk("R5 primary result", int'(reg_data), int'(exp_data(lr, ex_ch[lr])));
            chk("R6 primary end set", int'(reg_end), 1);
            cyc(3);
            chk("R6 primary end held", int'(reg_end), 1);
            reg_clr = 1'b1; @(negedge clk); reg_clr = 1'b0;
            chk("R6 primary end cleared", int'(reg_end), 0);
        end
        if (use_inj) begin
            chk("R6 priority end set", int'(inj_end), 1);
            inj_clr = 1'b1; @(negedge clk); inj_clr = 1'b0;
            chk("R6 priority end cleared", int'(inj_end), 0);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 16; i++) reg_chans[i*4 +: 4] = 4'($urandom_range(15, 0));
        for (int i = 0; i < 4; i++)  inj_chans[i*4 +: 4] = 4'($urandom_range(15, 0));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", nchk + 1, nbad);
            $finish;
        end
    end

    initial begin
        int n, p;
        int ex_order [0:7];
        void'($urandom(32'h5EED_0A1C));
        rst = 1'b1; pwr_en = 1'b0; div_sel = 2'd0;
        reg_start = 1'b0; inj_start = 1'b0; reg_clr = 1'b0; inj_clr = 1'b0;
        reg_len = '0; inj_len = '0; reg_chans = '0; inj_chans = '0;
        cyc(5);
        rst = 1'b0;
        cyc(2);
        chk("R8 reset ready low", int'(adc_ready), 0);
        chk("R10 reset no start", int'(conv_start), 0);
        chk("R6 reset flags low", int'(reg_end) + int'(inj_end), 0);
        chk("R5 reset primary result", int'(reg_data), 0);

        // R3: strobes while unpowered are dropped
        fill_random();
        reg_len = 4'd3;
        strobe_reg();
        strobe_inj();
        @(negedge clk); #1; log_n = 0;
        pwr_en = 1'b1;
        cyc(120);
        chk("R3 unpowered start ignored", log_n, 0);
        chk("R3 unpowered start no flag", int'(reg_end) + int'(inj_end), 0);

        // R8: settling time from a fresh power-on
        pwr_en = 1'b0; cyc(4);
        div_sel = 2'd0;
        pwr_en = 1'b1;
        n = 0;
        while (!adc_ready && n < 1000) begin @(negedge clk); n++; end
        chk("R8 settle within window", int'(n >= STAB*2 - 1 && n <= STAB*2 + 1), 1);

        // R7: each prescale ratio
        for (int s = 0; s < 4; s++) begin
            div_sel = 2'(s);
            cyc(20);
            measure(p);
            chk("R7 tick period", p, 2 * (s + 1));
        end
        div_sel = 2'd0; cyc(20);

        // R1: example order with repeats
        ex_order = '{3, 8, 2, 2, 0, 2, 2, 15};
        for (int i = 0; i < 8; i++) reg_chans[i*4 +: 4] = 4'(ex_order[i]);
        run_seq(8, 1, -1, 1'b1, 1'b0, "R1 example list");
        fill_random();
        run_seq(1, 1, -1, 1'b1, 1'b0, "R1 single slot");
        run_seq(16, 1, -1, 1'b1, 1'b0, "R1 full list");

        // R2: priority list alone
        run_seq(1, 4, -1, 1'b0, 1'b1, "R2 priority full");
        fill_random();
        run_seq(1, 1, -1, 1'b0, 1'b1, "R2 priority single");

        // R4: random interleaving
        for (int it = 0; it < 12; it++) begin
            int rl, il, at;
            fill_random();
            rl  = $urandom_range(16, 1);
            il  = $urandom_range(4, 1);
            at  = $urandom_range(rl - 1, 0);
            lat = $urandom_range(6, 2);
            run_seq(rl, il, at, 1'b1, 1'b1, "R4 merged list");
        end
        lat = 3;

        // R7: ratio change held off while busy
        lat = 40;
        reg_len = 4'd5;
        @(negedge clk); #1; log_n = 0;
        strobe_reg();
        wait_log(2);
        div_sel = 2'd3;
        cyc(4);
        measure(p);
        chk("R7 ratio held while busy", p, 2);
        n = 0;
        while (!reg_end && n < 20000) begin @(negedge clk); n++; end
        cyc(20);
        measure(p);
        chk("R7 ratio adopted when idle", p, 8);
        reg_clr = 1'b1; @(negedge clk); reg_clr = 1'b0;
        div_sel = 2'd0; cyc(20);
        lat = 4;

        // R9: power loss mid-list
        fill_random();
        reg_len = 4'd15;
        @(negedge clk); #1; log_n = 0;
        strobe_reg();
        wait_log(3);
        pwr_en = 1'b0;
        @(negedge clk);
        chk("R9 ready dropped", int'(adc_ready), 0);
        cyc(30);
        n = log_n;
        chk("R9 no flag after abort", int'(reg_end), 0);
        pwr_en = 1'b1;
        cyc(200);
        chk("R9 list not resumed", log_n, n);
        chk("R8 ready after repower", int'(adc_ready), 1);
        run_seq(5, 2, 1, 1'b1, 1'b1, "R4 after repower");

        finished = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule